// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames from a byte stream into memory buffers. Software builds a circular ring of four-word descriptors in memory and points the engine at the first one. For each frame, the engine fetches a descriptor it owns, fills that descriptor's buffer with the frame bytes in 32-bit words, and writes back the byte count. It then writes a status word that gives the descriptor back to software. After that it follows the descriptor's next pointer to the following one.

Each frame fits in a single buffer. Bytes beyond the buffer capacity are discarded and flagged. If the engine reaches a descriptor that software has not handed over, it raises a resource-error cause and enters a halted state. In that state it drains and discards incoming frames, and flags each one as an overrun, until software issues a new enable. There are four registers: a ring head pointer, a current descriptor pointer, a command register (enable, abort) and a sticky interrupt cause register.

The receive side is a valid/ready stream. A byte transfers on a rising edge where `rx_valid` and `rx_ready` are both high, and the source holds its byte and flags until that edge. `rx_ready` depends only on the engine state. It is low while idle, while fetching a descriptor and while any memory access is in progress, so the engine can stall the source at any time. The memory side is also a handshake. The engine holds a request stable until `mem_gnt`, and read data is taken on `mem_rvalid`, any number of cycles after the read was granted.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset the engine is idle. `rx_ready`, `mem_req` and `irq` are low, and every register reads zero.
- R2: Register index 0 is the ring head pointer, and writing it also loads the current pointer. Index 1 is the current pointer. Index 2 is the command register: bit 0 enables, bit 1 aborts, abort wins, and a read returns zero. Index 3 is the cause register: bit 0 frame done, bit 1 resource error, bit 2 overrun. `irq` is high while any cause bit is set.
- R3: An enable in the idle or halted state fetches four words from the current pointer: status at +0, size/count at +4, buffer address at +8 and next pointer at +12. Status bit 31 set means the device owns the descriptor. Buffer capacity in bytes is bits 31:16 of the size/count word. After the fetch, `rx_ready` goes high.
- R4: Frame bytes are packed little-endian, the first byte in bits 7:0, and each word is written to buffer + 4k. Unused lanes of a final partial word are zero. `rx_ready` is low whenever `mem_req` is high.
- R5: After the last byte, the engine writes the size/count word as {capacity, stored byte count}. It then writes the status word at +0 with bit 31 cleared, bits 17 and 16 (first, last) set, bit 23 (interrupt enable) copied from the fetched status, and bit 15 as the error summary.
- R6: Bytes beyond the capacity are dropped. The count equals the capacity, and status bits 15 and 1 are set.
- R7: A byte with `rx_err` high anywhere in the frame sets status bits 15 and 0.
- R8: When the status write completes, the current pointer takes the descriptor's next field and the next descriptor is fetched at once.
- R9: Cause bit 0 is set on a completed frame only if the descriptor's bit 23 was set.
- R10: A fetched status word with bit 31 clear sets cause bit 1. The engine writes nothing to that descriptor and halts. While halted it accepts and discards bytes and sets cause bit 2. A new enable fetches the current descriptor again.
- R11: An abort leaves `mem_req` and `rx_ready` low from the next cycle. The engine goes idle, the current pointer is unchanged, and a later enable resumes from it.
- R12: Writing zero to the cause register clears all bits, and writing a nonzero value changes nothing. A cause event in the same cycle as the clear still sets its bit.
- R13: A memory request keeps its address, direction and data stable until granted, and a read completes only when `mem_rvalid` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | High while any cause bit is set |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Engine accepts a byte this cycle |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_err | input | 1 | Byte was received with an error |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
A memory write is due on the edge where the request meets a grant. The monitor compares it at the falling edge before that edge, against a queue filled by the frame driver, so the grant throttling cannot shift a comparison. Cause bits and the current pointer change on the same edge as the status write. Register reads are therefore checked only once the expected-write queue has drained and a few idle cycles have passed. Abort takes effect one edge after the command write, and the bench samples `rx_ready` and `mem_req` at the very next falling edge.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int CNT_W   = 16;
  localparam int LANES   = 4;
  localparam int OWN_BIT   = 31;
  localparam int IE_BIT    = 23;
  localparam int FIRST_BIT = 17;
  localparam int LAST_BIT  = 16;
  localparam int ESUM_BIT  = 15;
  localparam int TRUNC_BIT = 1;
  localparam int SERR_BIT  = 0;
  localparam logic [1:0] RA_FIRST = 2'd0;
  localparam logic [1:0] RA_CUR   = 2'd1;
  localparam logic [1:0] RA_CMD   = 2'd2;
  localparam logic [1:0] RA_CAUSE = 2'd3;
  localparam int CAUSE_W   = 3;
  localparam int CB_DONE   = 0;
  localparam int CB_RESERR = 1;
  localparam int CB_OVR    = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_CMD, ST_RD_SIZE, ST_RD_BUF, ST_RD_NEXT,
    ST_RECV, ST_WR_DATA, ST_WR_CNT, ST_WR_STAT, ST_HALT
  } seq_state_e;
endpackage

// File: rtl/rxring_regs.sv
module rxring_regs
  import rxring_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               adv,
  input  logic [AW-1:0]      adv_ptr,
  input  logic               ev_done,
  input  logic               ev_reserr,
  input  logic               ev_ovr,
  output logic [AW-1:0]      cur_ptr,
  output logic               go,
  output logic               stop,
  output logic [CAUSE_W-1:0] cause
);
  logic [AW-1:0]      first_q, cur_q;
  logic [CAUSE_W-1:0] cause_q, cause_n;
  logic wr_first, wr_cur, wr_cmd, wr_cause;

  assign wr_first = reg_wr && (reg_addr == RA_FIRST);
  assign wr_cur   = reg_wr && (reg_addr == RA_CUR);
  assign wr_cmd   = reg_wr && (reg_addr == RA_CMD);
  assign wr_cause = reg_wr && (reg_addr == RA_CAUSE);

  assign stop = wr_cmd && reg_wdata[1];
  assign go   = wr_cmd && reg_wdata[0] && !reg_wdata[1];

  always_comb begin
    cause_n = cause_q;
    if (wr_cause && (reg_wdata == 32'd0)) cause_n = '0;
    cause_n[CB_DONE]   = cause_n[CB_DONE]   | ev_done;
    cause_n[CB_RESERR] = cause_n[CB_RESERR] | ev_reserr;
    cause_n[CB_OVR]    = cause_n[CB_OVR]    | ev_ovr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      cur_q   <= '0;
      cause_q <= '0;
    end else begin
      cause_q <= cause_n;
      if (wr_first) begin
        first_q <= reg_wdata[AW-1:0];
        cur_q   <= reg_wdata[AW-1:0];
      end else if (wr_cur) begin
        cur_q <= reg_wdata[AW-1:0];
      end else if (adv) begin
        cur_q <= adv_ptr;
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      RA_FIRST: reg_rdata = 32'(first_q);
      RA_CUR:   reg_rdata = 32'(cur_q);
      RA_CMD:   reg_rdata = 32'd0;
      default:  reg_rdata = 32'(cause_q);
    endcase
  end

  assign cur_ptr = cur_q;
  assign cause   = cause_q;
endmodule

// File: rtl/rxring_packer.sv
module rxring_packer
  import rxring_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_frame,
  input  logic             clr_word,
  input  logic             take,
  input  logic [7:0]       data,
  input  logic [CNT_W-1:0] cap,
  output logic [31:0]      word,
  output logic [1:0]       lane,
  output logic [CNT_W-1:0] count,
  output logic             trunc,
  output logic             room
);
  logic [1:0]       lane_q;
  logic [CNT_W-1:0] cnt_q;
  logic             trunc_q;
  logic             store;

  assign room  = (cnt_q < cap);
  assign store = take && room;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] b_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    b_q <= '0;
      else if (clr_frame || clr_word)                b_q <= '0;
      else if (store && (lane_q == 2'(g)))           b_q <= data;
    end
    assign word[g*8 +: 8] = b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q  <= '0;
      cnt_q   <= '0;
      trunc_q <= 1'b0;
    end else if (clr_frame) begin
      lane_q  <= '0;
      cnt_q   <= '0;
      trunc_q <= 1'b0;
    end else if (take) begin
      if (room) begin
        lane_q <= lane_q + 2'd1;
        cnt_q  <= cnt_q + 1'b1;
      end else begin
        trunc_q <= 1'b1;
      end
    end
  end

  assign lane  = lane_q;
  assign count = cnt_q;
  assign trunc = trunc_q;
endmodule

// File: rtl/rxring_seq.sv
module rxring_seq
  import rxring_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             stop,
  input  logic [AW-1:0]    cur_ptr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata,
  input  logic             rx_valid,
  input  logic             rx_last,
  input  logic             rx_err,
  output logic             rx_ready,
  output logic             take,
  output logic             clr_frame,
  output logic             clr_word,
  output logic [CNT_W-1:0] cap,
  input  logic [31:0]      word,
  input  logic [1:0]       lane,
  input  logic [CNT_W-1:0] count,
  input  logic             trunc,
  input  logic             room,
  output logic             adv,
  output logic [AW-1:0]    adv_ptr,
  output logic             ev_done,
  output logic             ev_reserr,
  output logic             ev_ovr
);
  localparam logic [AW-1:0] OFS_SIZE = AW'(4);
  localparam logic [AW-1:0] OFS_BUF  = AW'(8);
  localparam logic [AW-1:0] OFS_NEXT = AW'(12);

  seq_state_e       state, nxt;
  logic             rd_pend, rd_stale, ie_q, serr_q, frame_end_q;
  logic [CNT_W-1:0] cap_q;
  logic [AW-1:0]    buf_q, next_q;
  logic             is_rd, is_wr, fire, rd_fire, wr_fire, got;
  logic [CNT_W-1:0] cnt_m1;
  logic [31:0]      status_w;

  assign is_rd   = (state == ST_RD_CMD) || (state == ST_RD_SIZE) ||
                   (state == ST_RD_BUF) || (state == ST_RD_NEXT);
  assign is_wr   = (state == ST_WR_DATA) || (state == ST_WR_CNT) || (state == ST_WR_STAT);
  assign rx_ready = (state == ST_RECV) || (state == ST_HALT);
  assign fire    = rx_valid && rx_ready;
  assign take    = fire && (state == ST_RECV);
  assign mem_req = (is_rd && !rd_pend && !rd_stale) || is_wr;
  assign mem_we  = is_wr;
  assign rd_fire = mem_req && !mem_we && mem_gnt;
  assign wr_fire = mem_req && mem_we && mem_gnt;
  assign got     = mem_rvalid && rd_pend && !rd_stale && is_rd;
  assign cap     = cap_q;
  assign adv_ptr = next_q;
  assign cnt_m1  = count - 1'b1;

  always_comb begin
    status_w = '0;
    status_w[FIRST_BIT] = 1'b1;
    status_w[LAST_BIT]  = 1'b1;
    status_w[IE_BIT]    = ie_q;
    status_w[ESUM_BIT]  = trunc | serr_q;
    status_w[TRUNC_BIT] = trunc;
    status_w[SERR_BIT]  = serr_q;
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_RD_CMD:  mem_addr = cur_ptr;
      ST_RD_SIZE: mem_addr = cur_ptr + OFS_SIZE;
      ST_RD_BUF:  mem_addr = cur_ptr + OFS_BUF;
      ST_RD_NEXT: mem_addr = cur_ptr + OFS_NEXT;
      ST_WR_DATA: begin
        mem_addr  = buf_q + AW'({cnt_m1[CNT_W-1:2], 2'b00});
        mem_wdata = word;
      end
      ST_WR_CNT: begin
        mem_addr  = cur_ptr + OFS_SIZE;
        mem_wdata = {cap_q, count};
      end
      ST_WR_STAT: begin
        mem_addr  = cur_ptr;
        mem_wdata = status_w;
      end
      default: ;
    endcase
  end

  always_comb begin
    nxt       = state;
    ev_reserr = 1'b0;
    ev_done   = 1'b0;
    ev_ovr    = 1'b0;
    adv       = 1'b0;
    clr_frame = 1'b0;
    clr_word  = 1'b0;
    unique case (state)
      ST_IDLE: if (go) nxt = ST_RD_CMD;
      ST_HALT: begin
        if (fire) ev_ovr = 1'b1;
        if (go)   nxt = ST_RD_CMD;
      end
      ST_RD_CMD: if (got) begin
        if (mem_rdata[OWN_BIT]) nxt = ST_RD_SIZE;
        else begin
          nxt       = ST_HALT;
          ev_reserr = 1'b1;
        end
      end
      ST_RD_SIZE: if (got) nxt = ST_RD_BUF;
      ST_RD_BUF:  if (got) nxt = ST_RD_NEXT;
      ST_RD_NEXT: if (got) begin
        nxt       = ST_RECV;
        clr_frame = 1'b1;
      end
      ST_RECV: if (fire) begin
        if (room && (lane == 2'd3)) nxt = ST_WR_DATA;
        else if (rx_last)           nxt = (room || (lane != 2'd0)) ? ST_WR_DATA : ST_WR_CNT;
      end
      ST_WR_DATA: if (wr_fire) begin
        clr_word = 1'b1;
        nxt      = frame_end_q ? ST_WR_CNT : ST_RECV;
      end
      ST_WR_CNT: if (wr_fire) nxt = ST_WR_STAT;
      ST_WR_STAT: if (wr_fire) begin
        adv     = 1'b1;
        ev_done = ie_q;
        nxt     = ST_RD_CMD;
      end
      default: nxt = ST_IDLE;
    endcase
    if (stop) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      rd_pend     <= 1'b0;
      rd_stale    <= 1'b0;
      ie_q        <= 1'b0;
      serr_q      <= 1'b0;
      frame_end_q <= 1'b0;
      cap_q       <= '0;
      buf_q       <= '0;
      next_q      <= '0;
    end else begin
      state <= nxt;
      if (rd_fire)         rd_pend <= 1'b1;
      else if (mem_rvalid) rd_pend <= 1'b0;
      if (stop && ((rd_pend && !mem_rvalid) || rd_fire)) rd_stale <= 1'b1;
      else if (mem_rvalid)                               rd_stale <= 1'b0;
      if (got) begin
        unique case (state)
          ST_RD_CMD:  ie_q   <= mem_rdata[IE_BIT];
          ST_RD_SIZE: cap_q  <= mem_rdata[31:16];
          ST_RD_BUF:  buf_q  <= mem_rdata[AW-1:0];
          ST_RD_NEXT: next_q <= mem_rdata[AW-1:0];
          default: ;
        endcase
      end
      if (clr_frame)           serr_q <= 1'b0;
      else if (take && rx_err) serr_q <= 1'b1;
      if (take) frame_end_q <= rx_last;
    end
  end
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
  import rxring_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata
);
  logic [AW-1:0]      cur_ptr_w, adv_ptr_w;
  logic [CAUSE_W-1:0] cause_w;
  logic go_w, stop_w, adv_w, ev_done_w, ev_reserr_w, ev_ovr_w;
  logic take_w, clr_frame_w, clr_word_w, trunc_w, room_w;
  logic [CNT_W-1:0] cap_w, count_w;
  logic [31:0] word_w;
  logic [1:0]  lane_w;

  rxring_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adv(adv_w), .adv_ptr(adv_ptr_w),
    .ev_done(ev_done_w), .ev_reserr(ev_reserr_w), .ev_ovr(ev_ovr_w),
    .cur_ptr(cur_ptr_w), .go(go_w), .stop(stop_w), .cause(cause_w)
  );

  rxring_packer u_pack (
    .clk(clk), .rst_n(rst_n), .clr_frame(clr_frame_w), .clr_word(clr_word_w),
    .take(take_w), .data(rx_data), .cap(cap_w), .word(word_w), .lane(lane_w),
    .count(count_w), .trunc(trunc_w), .room(room_w)
  );

  rxring_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go_w), .stop(stop_w), .cur_ptr(cur_ptr_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rx_valid(rx_valid), .rx_last(rx_last), .rx_err(rx_err), .rx_ready(rx_ready),
    .take(take_w), .clr_frame(clr_frame_w), .clr_word(clr_word_w), .cap(cap_w),
    .word(word_w), .lane(lane_w), .count(count_w), .trunc(trunc_w), .room(room_w),
    .adv(adv_w), .adv_ptr(adv_ptr_w), .ev_done(ev_done_w), .ev_reserr(ev_reserr_w),
    .ev_ovr(ev_ovr_w)
  );

  assign irq = |cause_w;
endmodule

// File: rtl/rxring_checks.sv
module rxring_checks #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_gnt,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          rx_ready,
  input logic [2:0]    cause,
  input logic [AW-1:0] cur_ptr
);
  logic abort_wr, cause_clr;
  assign abort_wr  = reg_wr && (reg_addr == 2'd2) && reg_wdata[1];
  assign cause_clr = reg_wr && (reg_addr == 2'd3) && (reg_wdata == 32'd0);

  assert_abort_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort_wr |=> (!mem_req && !rx_ready));

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !reg_wr) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_no_take_during_mem_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !rx_ready);

  assert_status_handback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && (mem_addr == cur_ptr)) |->
      (!mem_wdata[31] && mem_wdata[17] && mem_wdata[16]));

  assert_count_within_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && (mem_addr == cur_ptr + AW'(4))) |->
      (mem_wdata[15:0] <= mem_wdata[31:16]));

  for (genvar b = 0; b < 3; b++) begin : g_sticky
    assert_cause_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cause[b] && !cause_clr) |=> cause[b]);
  end
endmodule

bind rx_ring_engine rxring_checks #(.AW(AW)) u_checks (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mem_req(mem_req), .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .rx_ready(rx_ready), .cause(cause_w), .cur_ptr(cur_ptr_w)
);

// File: tb/rx_ring_engine_test.sv
module rx_ring_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [1:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata; logic irq;
  logic rx_valid = 0, rx_ready, rx_last = 0, rx_err = 0; logic [7:0] rx_data = 0;
  logic mem_req, mem_we; logic [AW-1:0] mem_addr; logic [31:0] mem_wdata;
  logic mem_gnt = 0, mem_rvalid = 0; logic [31:0] mem_rdata = 0;

  logic [31:0] mem [0:255];
  logic [7:0]  lfsr = 8'hA5;
  int checks = 0, errors = 0;
  logic [31:0] exp_addr[$], exp_data[$];
  string       exp_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_ring_engine #(.AW(AW)) uut (.*);

  // memory model with throttled grants and one-cycle read latency
  always @(posedge clk) begin
    lfsr       <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_gnt    <= lfsr[0] | lfsr[2];
    mem_rvalid <= 1'b0;
    if (mem_req && mem_gnt && !mem_we) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem[mem_addr[9:2]];
    end
    if (mem_req && mem_gnt && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
  end

  // scoreboard monitor: a write happens on the next rising edge
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we && mem_gnt) begin
      checks++;
      if (exp_addr.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected write addr=%h data=%h expected none", mem_addr, mem_wdata);
      end else begin
        if (mem_addr != exp_addr[0] || mem_wdata != exp_data[0]) begin
          errors++;
          $display("FAIL %s write addr=%h data=%h expected addr=%h data=%h",
                   exp_tag[0], mem_addr, mem_wdata, exp_addr[0], exp_data[0]);
        end
        void'(exp_addr.pop_front()); void'(exp_data.pop_front()); void'(exp_tag.pop_front());
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_check(input string tag, input logic [1:0] a, input logic [31:0] exp);
    @(negedge clk); reg_addr = a; #1;
    check(tag, reg_rdata, exp);
  endtask

  function automatic logic [7:0] fbyte(input logic [7:0] base, input int i);
    return base + 8'(i);
  endfunction

  task automatic expect_frame(input logic [31:0] desc, input logic [31:0] bufa,
                              input int cap, input bit ie, input int len,
                              input logic [7:0] base, input int err_at, input string tag);
    int n = (len < cap) ? len : cap;
    logic [31:0] st;
    for (int w = 0; w < (n + 3) / 4; w++) begin
      logic [31:0] d = '0;
      for (int l = 0; l < 4; l++)
        if (w*4 + l < n) d[l*8 +: 8] = fbyte(base, w*4 + l);
      exp_addr.push_back(bufa + 32'(w*4)); exp_data.push_back(d); exp_tag.push_back(tag);
    end
    exp_addr.push_back(desc + 4); exp_data.push_back({16'(cap), 16'(n)}); exp_tag.push_back(tag);
    st = 32'h0003_0000;
    st[23] = ie;
    st[1]  = (len > cap);
    st[0]  = (err_at >= 0);
    st[15] = st[1] | st[0];
    exp_addr.push_back(desc); exp_data.push_back(st); exp_tag.push_back(tag);
  endtask

  task automatic send_frame(input int len, input logic [7:0] base, input int err_at);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = fbyte(base, i); rx_last = (i == len - 1); rx_err = (i == err_at);
      while (!rx_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk); rx_valid = 0; rx_last = 0; rx_err = 0;
  endtask

  task automatic drain;
    while (exp_addr.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    // ring: 0x00 -> 0x10 -> 0x20 -> 0x00
    mem[0]  = 32'h8080_0000; mem[1]  = {16'd64, 16'd0}; mem[2]  = 32'h100; mem[3]  = 32'h10;
    mem[4]  = 32'h8000_0000; mem[5]  = {16'd6,  16'd0}; mem[6]  = 32'h200; mem[7]  = 32'h20;
    mem[8]  = 32'h8080_0000; mem[9]  = {16'd64, 16'd0}; mem[10] = 32'h300; mem[11] = 32'h00;
    repeat (5) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    @(negedge clk);
    check("R1 rx_ready", 32'(rx_ready), 0);
    check("R1 mem_req", 32'(mem_req), 0);
    check("R1 irq", 32'(irq), 0);
    reg_check("R1 cur ptr", 2'd1, 0);
    reg_check("R1 cause", 2'd3, 0);

    // R2 register map
    reg_write(2'd0, 32'h0);
    reg_write(2'd1, 32'h40);
    reg_check("R2 cur write", 2'd1, 32'h40);
    reg_write(2'd0, 32'h0);
    reg_check("R2 head loads cur", 2'd1, 32'h0);
    reg_check("R2 cmd reads zero", 2'd2, 32'h0);

    // frame A: 9 bytes into desc 0x00, interrupt enabled
    reg_write(2'd2, 32'h1);
    expect_frame(32'h00, 32'h100, 64, 1, 9, 8'h10, -1, "R3,R4,R5");
    send_frame(9, 8'h10, -1);
    drain();
    reg_check("R9 done cause", 2'd3, 32'h1);
    check("R2 irq on cause", 32'(irq), 1);
    reg_check("R8 cur advanced", 2'd1, 32'h10);
    reg_write(2'd3, 32'h0);
    reg_check("R12 clear by zero", 2'd3, 32'h0);

    // frame B: 10 bytes into cap-6 buffer, error on byte 3, no interrupt enable
    expect_frame(32'h10, 32'h200, 6, 0, 10, 8'h40, 3, "R6,R7");
    send_frame(10, 8'h40, 3);
    drain();
    reg_check("R9 no done without enable", 2'd3, 32'h0);
    reg_check("R8 cur advanced", 2'd1, 32'h20);

    // frame C: exact word, then desc 0x00 is software-owned -> halt
    expect_frame(32'h20, 32'h300, 64, 1, 4, 8'h80, -1, "R4,R13");
    send_frame(4, 8'h80, -1);
    drain();
    reg_check("R10 resource error", 2'd3, 32'h3);
    reg_check("R8 wrap to head", 2'd1, 32'h0);
    reg_write(2'd3, 32'h7);
    reg_check("R12 nonzero write no effect", 2'd3, 32'h3);

    // frame D while halted: drained, no writes, overrun cause
    @(negedge clk);
    check("R10 halted accepts", 32'(rx_ready), 1);
    send_frame(3, 8'hC0, -1);
    repeat (12) @(negedge clk);
    reg_check("R10 overrun cause", 2'd3, 32'h7);
    reg_write(2'd3, 32'h0);

    // re-arm desc 0x00, enable, then abort after fetch
    mem[0] = 32'h8080_0000; mem[1] = {16'd64, 16'd0};
    reg_write(2'd2, 32'h1);
    repeat (40) @(negedge clk);
    check("R3 ready after fetch", 32'(rx_ready), 1);
    @(negedge clk); reg_wr = 1; reg_addr = 2'd2; reg_wdata = 32'h3;
    @(negedge clk); reg_wr = 0;
    check("R11 abort rx_ready", 32'(rx_ready), 0);
    check("R11 abort mem_req", 32'(mem_req), 0);
    repeat (4) @(negedge clk);
    check("R11 idle stays quiet", 32'(rx_ready), 0);
    reg_check("R11 cur unchanged", 2'd1, 32'h0);

    // resume: frame E into desc 0x00, then desc 0x10 is not owned
    reg_write(2'd2, 32'h1);
    expect_frame(32'h00, 32'h100, 64, 1, 5, 8'hE0, -1, "R11");
    send_frame(5, 8'hE0, -1);
    drain();
    reg_check("R11 resumed frame done", 2'd3, 32'h3);
    reg_check("R8 cur after resume", 2'd1, 32'h10);
    check("R5 all writes seen", 32'(exp_addr.size()), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule